// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 77 interrupt inputs and drives one interrupt request line toward a processor. Software reaches it over a simple word-addressed register bus. A source-select register picks one source at a time. The mode, vector, enable, disable and clear registers then act on that source alone. Each source carries a trigger type, a three-bit priority and a 32-bit vector.

While the request line is high, the handler reads the vector register. That read returns the vector of the winning source and acknowledges it: any edge latch of that source is cleared, and the current service level is pushed onto an eight-deep nesting stack. A later write to the end-of-interrupt register restores the previous level. The block also has a spurious vector, returned when no source qualifies, and a keyed write-protect register that locks the configuration. A debug bit makes vector reads free of side effects.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The source-select register (offset 0) holds a source number below NSRC, and writes of larger numbers are ignored. Mode (offset 1) and vector (offset 2) reads and writes, and enable, disable and clear writes, act only on the selected source.
- R2: The mode word places the priority in bits [2:0] (0 to 7, higher wins) and the trigger in bits [5:4]: 0 high level, 1 rising edge, 2 low level, 3 falling edge. All other bits read as zero.
- R3: A mode write with trigger 2 or 3 to a source that is not marked in EXT_MASK is dropped as a whole, and the previous mode stays in place.
- R4: Edge sources latch a pending flag on the chosen edge, whether or not the source is enabled. Level sources are pending while the input sits at the chosen level.
- R5: Writing a word with bit 0 set to enable (offset 3) enables the selected source, and the same write to disable (offset 4) disables it. A write with bit 0 set to clear (offset 5) drops its edge latch. Reading offset 3 returns {pending, enabled} in bits [1:0].
- R6: The winner is chosen among pending, enabled sources whose priority is strictly above the current service level. The highest priority wins, and ties go to the lowest source number. The request line is high whenever a winner exists.
- R7: A vector read (offset 6) with a winner returns that winner's vector. It also clears that source's edge latch, pushes the current level and raises the level to the winner's priority, so the request line drops unless a higher priority source is pending.
- R8: Any write to end-of-interrupt (offset 7) pops one stack level. With an empty stack it has no effect. The status read (offset 11) shows the level code (0 idle, else priority+1) in bits [7:4] and the stack depth in bits [3:0].
- R9: A vector read with no winner returns the spurious register (offset 8) and leaves the stack unchanged.
- R10: A write to offset 9 whose bits [31:8] equal WP_KEY sets the protect flag to bit 0, and writes with any other key are ignored. While the flag is set, writes to mode, vector, spurious and debug are ignored.
- R11: With the debug bit (offset 10, bit 0) set, a vector read returns the winner's vector but leaves the latches, the stack and the request line unchanged.
- R12: After reset the request line is low, the stack is empty and the level is idle. Every read returns its data with bus_rvalid one clock after bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_rd |
| src_in | input | NSRC | Interrupt source inputs |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same clock. They also assume that an end-of-interrupt write is never combined with an acknowledging read, because the stack gives a push priority over a pop. The bench drives each bus access as a single strobe cycle from its tasks, so these collisions never occur. Source inputs change only on falling clock edges and are held for at least one full clock, so every edge is seen by the input register.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int PRIO_W = 3;
  localparam int NPRIO  = 1 << PRIO_W;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef struct packed {
    trig_e               trig;
    logic [PRIO_W-1:0]   prio;
  } src_mode_t;

  localparam logic [3:0] RA_SEL  = 4'd0;
  localparam logic [3:0] RA_MODE = 4'd1;
  localparam logic [3:0] RA_VEC  = 4'd2;
  localparam logic [3:0] RA_ENA  = 4'd3;
  localparam logic [3:0] RA_DIS  = 4'd4;
  localparam logic [3:0] RA_CLR  = 4'd5;
  localparam logic [3:0] RA_IVR  = 4'd6;
  localparam logic [3:0] RA_EOI  = 4'd7;
  localparam logic [3:0] RA_SPUR = 4'd8;
  localparam logic [3:0] RA_WPR  = 4'd9;
  localparam logic [3:0] RA_DBG  = 4'd10;
  localparam logic [3:0] RA_STAT = 4'd11;

  function automatic src_mode_t mode_from_word(input logic [31:0] w);
    src_mode_t m;
    m.trig = trig_e'(w[5:4]);
    m.prio = w[PRIO_W-1:0];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_word(input src_mode_t m);
    logic [31:0] w;
    w = '0;
    w[5:4] = m.trig;
    w[PRIO_W-1:0] = m.prio;
    return w;
  endfunction

endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank
  import pic_pkg::*;
#(
  parameter int               NSRC     = 77,
  parameter logic [NSRC-1:0]  EXT_MASK = '0,
  parameter int               SRC_W    = $clog2(NSRC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         src_in,
  input  logic [SRC_W-1:0]        sel,
  input  logic                    mode_we,
  input  src_mode_t               mode_wd,
  input  logic                    en_we,
  input  logic                    dis_we,
  input  logic                    clr_we,
  input  logic                    ack,
  input  logic [SRC_W-1:0]        ack_idx,
  output src_mode_t [NSRC-1:0]    modes,
  output logic [NSRC-1:0]         en_o,
  output logic [NSRC-1:0]         pend_o,
  output logic [NSRC-1:0]         act_o
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic IS_EXT = EXT_MASK[g];

    src_mode_t mode_q;
    logic      en_q;
    logic      lat_q;
    logic      in_q;
    logic      in_prev;
    logic      hit;
    logic      acked;
    logic      edge_seen;
    logic      level_on;
    logic      mode_legal;

    assign hit        = (sel == SRC_W'(g));
    assign acked      = ack && (ack_idx == SRC_W'(g));
    assign mode_legal = IS_EXT || !mode_wd.trig[1];

    always_comb begin
      edge_seen = 1'b0;
      level_on  = 1'b0;
      case (mode_q.trig)
        TRIG_RISE: edge_seen = in_q & ~in_prev;
        TRIG_FALL: edge_seen = ~in_q & in_prev;
        TRIG_HIGH: level_on  = in_q;
        TRIG_LOW:  level_on  = ~in_q;
        default:   level_on  = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q  <= '0;
        en_q    <= 1'b0;
        lat_q   <= 1'b0;
        in_q    <= 1'b0;
        in_prev <= 1'b0;
      end else begin
        in_q    <= src_in[g];
        in_prev <= in_q;
        if (hit && mode_we && mode_legal)
          mode_q <= mode_wd;
        if (hit && en_we)
          en_q <= 1'b1;
        else if (hit && dis_we)
          en_q <= 1'b0;
        if (edge_seen)
          lat_q <= 1'b1;
        else if ((hit && clr_we) || acked)
          lat_q <= 1'b0;
      end
    end

    assign modes[g]  = mode_q;
    assign en_o[g]   = en_q;
    assign pend_o[g] = mode_q.trig[0] ? lat_q : level_on;
    assign act_o[g]  = en_q & pend_o[g];
  end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NSRC  = 77,
  parameter int SRC_W = $clog2(NSRC),
  parameter int LVL_W = 4
) (
  input  logic [NSRC-1:0]       act,
  input  src_mode_t [NSRC-1:0]  modes,
  input  logic [LVL_W-1:0]      cur_lvl,
  output logic                  win_valid,
  output logic [SRC_W-1:0]      win_idx,
  output logic [PRIO_W-1:0]     win_prio
);

  logic [NSRC-1:0] elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = act[g] && ((LVL_W'(modes[g].prio) + LVL_W'(1)) > cur_lvl);
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!win_valid || modes[i].prio >= win_prio)) begin
        win_valid = 1'b1;
        win_idx   = SRC_W'(i);
        win_prio  = modes[i].prio;
      end
    end
  end

endmodule

// File: rtl/pic_prio_stack.sv
module pic_prio_stack #(
  parameter int STACK_D = 8,
  parameter int LVL_W   = 4,
  parameter int DEP_W   = $clog2(STACK_D + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [LVL_W-1:0]   push_lvl,
  input  logic               pop,
  output logic [LVL_W-1:0]   cur_lvl,
  output logic [DEP_W-1:0]   depth
);

  localparam int IDX_W = (STACK_D > 1) ? $clog2(STACK_D) : 1;

  logic [LVL_W-1:0] slot [STACK_D];
  logic [DEP_W-1:0] depth_m1;
  logic             can_push;
  logic             can_pop;

  assign depth_m1 = depth - DEP_W'(1);
  assign can_push = push && (depth < DEP_W'(STACK_D));
  assign can_pop  = pop && (depth != '0);

  always_ff @(posedge clk) begin
    if (can_push)
      slot[depth[IDX_W-1:0]] <= cur_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl <= '0;
      depth   <= '0;
    end else if (can_push) begin
      cur_lvl <= push_lvl;
      depth   <= depth + DEP_W'(1);
    end else if (can_pop) begin
      cur_lvl <= slot[depth_m1[IDX_W-1:0]];
      depth   <= depth_m1;
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int              NSRC     = 77,
  parameter logic [NSRC-1:0] EXT_MASK = {16'hFFFF, 61'd0},
  parameter int              ADDR_W   = 4,
  parameter logic [23:0]     WP_KEY   = 24'h5EC0DE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NSRC-1:0]    src_in,
  output logic               irq_out
);

  localparam int SRC_W   = $clog2(NSRC);
  localparam int STACK_D = NPRIO;
  localparam int LVL_W   = $clog2(NPRIO + 1);
  localparam int DEP_W   = $clog2(STACK_D + 1);

  logic [SRC_W-1:0]      sel_q;
  logic [31:0]           spur_q;
  logic                  prot_q;
  logic                  dbg_q;
  logic [31:0]           vec_mem [NSRC];

  src_mode_t [NSRC-1:0]  src_modes;
  logic [NSRC-1:0]       src_en;
  logic [NSRC-1:0]       src_pend;
  logic [NSRC-1:0]       src_act;

  logic                  win_valid;
  logic [SRC_W-1:0]      win_idx;
  logic [PRIO_W-1:0]     win_prio;
  logic [LVL_W-1:0]      cur_lvl;
  logic [DEP_W-1:0]      stk_depth;

  logic wr_sel, wr_mode, wr_vec, wr_en, wr_dis, wr_clr, wr_eoi;
  logic wr_spur, wr_wpr, wr_dbg, rd_ivr, ack;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [3:0] off);
    return a == ADDR_W'(off);
  endfunction

  assign wr_sel  = bus_wr && at(bus_addr, RA_SEL) && (bus_wdata < 32'(NSRC));
  assign wr_mode = bus_wr && at(bus_addr, RA_MODE) && !prot_q;
  assign wr_vec  = bus_wr && at(bus_addr, RA_VEC)  && !prot_q;
  assign wr_en   = bus_wr && at(bus_addr, RA_ENA)  && bus_wdata[0];
  assign wr_dis  = bus_wr && at(bus_addr, RA_DIS)  && bus_wdata[0];
  assign wr_clr  = bus_wr && at(bus_addr, RA_CLR)  && bus_wdata[0];
  assign wr_eoi  = bus_wr && at(bus_addr, RA_EOI);
  assign wr_spur = bus_wr && at(bus_addr, RA_SPUR) && !prot_q;
  assign wr_wpr  = bus_wr && at(bus_addr, RA_WPR)  && (bus_wdata[31:8] == WP_KEY);
  assign wr_dbg  = bus_wr && at(bus_addr, RA_DBG)  && !prot_q;
  assign rd_ivr  = bus_rd && at(bus_addr, RA_IVR);
  assign ack     = rd_ivr && win_valid && !dbg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      spur_q <= '0;
      prot_q <= 1'b0;
      dbg_q  <= 1'b0;
    end else begin
      if (wr_sel)  sel_q  <= bus_wdata[SRC_W-1:0];
      if (wr_spur) spur_q <= bus_wdata;
      if (wr_wpr)  prot_q <= bus_wdata[0];
      if (wr_dbg)  dbg_q  <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_vec)
      vec_mem[sel_q] <= bus_wdata;
  end

  pic_src_bank #(
    .NSRC     (NSRC),
    .EXT_MASK (EXT_MASK),
    .SRC_W    (SRC_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .src_in  (src_in),
    .sel     (sel_q),
    .mode_we (wr_mode),
    .mode_wd (mode_from_word(bus_wdata)),
    .en_we   (wr_en),
    .dis_we  (wr_dis),
    .clr_we  (wr_clr),
    .ack     (ack),
    .ack_idx (win_idx),
    .modes   (src_modes),
    .en_o    (src_en),
    .pend_o  (src_pend),
    .act_o   (src_act)
  );

  pic_arbiter #(
    .NSRC  (NSRC),
    .SRC_W (SRC_W),
    .LVL_W (LVL_W)
  ) u_arb (
    .act       (src_act),
    .modes     (src_modes),
    .cur_lvl   (cur_lvl),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  pic_prio_stack #(
    .STACK_D (STACK_D),
    .LVL_W   (LVL_W),
    .DEP_W   (DEP_W)
  ) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (ack),
    .push_lvl (LVL_W'(win_prio) + LVL_W'(1)),
    .pop      (wr_eoi),
    .cur_lvl  (cur_lvl),
    .depth    (stk_depth)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq_out    <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      irq_out    <= win_valid;
      if (bus_rd) begin
        bus_rdata <= '0;
        if (at(bus_addr, RA_SEL))  bus_rdata <= 32'(sel_q);
        if (at(bus_addr, RA_MODE)) bus_rdata <= mode_to_word(src_modes[sel_q]);
        if (at(bus_addr, RA_VEC))  bus_rdata <= vec_mem[sel_q];
        if (at(bus_addr, RA_ENA))  bus_rdata <= {30'd0, src_pend[sel_q], src_en[sel_q]};
        if (at(bus_addr, RA_IVR))  bus_rdata <= win_valid ? vec_mem[win_idx] : spur_q;
        if (at(bus_addr, RA_SPUR)) bus_rdata <= spur_q;
        if (at(bus_addr, RA_WPR))  bus_rdata <= {31'd0, prot_q};
        if (at(bus_addr, RA_DBG))  bus_rdata <= {31'd0, dbg_q};
        if (at(bus_addr, RA_STAT)) bus_rdata <= {24'd0, 4'(cur_lvl), 4'(stk_depth)};
      end
    end
  end

endmodule

// File: rtl/pic_checks.sv
module pic_checks
  import pic_pkg::*;
#(
  parameter int NSRC   = 77,
  parameter int ADDR_W = 4,
  parameter int SRC_W  = 7,
  parameter int LVL_W  = 4,
  parameter int DEP_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rvalid,
  input logic               prot,
  input logic               dbg,
  input logic [SRC_W-1:0]   sel,
  input src_mode_t [NSRC-1:0] modes,
  input logic [NSRC-1:0]    src_en,
  input logic               win_valid,
  input logic [SRC_W-1:0]   win_idx,
  input logic [LVL_W-1:0]   cur_lvl,
  input logic [DEP_W-1:0]   depth
);

  logic is_ivr_rd, is_eoi_wr, is_mode_wr;
  assign is_ivr_rd  = bus_rd && !bus_wr && (bus_addr == ADDR_W'(RA_IVR));
  assign is_eoi_wr  = bus_wr && !bus_rd && (bus_addr == ADDR_W'(RA_EOI));
  assign is_mode_wr = bus_wr && (bus_addr == ADDR_W'(RA_MODE));

  a_r12_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  a_r12_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  a_r6_winner_enabled: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> src_en[win_idx]);

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth <= DEP_W'(NPRIO));

  a_r7_ack_pushes: assert property (@(posedge clk) disable iff (rst)
    (is_ivr_rd && win_valid && !dbg) |=>
      (depth == $past(depth) + DEP_W'(1)) && (cur_lvl > $past(cur_lvl)));

  a_r8_eoi_pops: assert property (@(posedge clk) disable iff (rst)
    (is_eoi_wr && depth != '0) |=> depth == $past(depth) - DEP_W'(1));

  a_r8_eoi_empty: assert property (@(posedge clk) disable iff (rst)
    (is_eoi_wr && depth == '0) |=> (depth == '0) && $stable(cur_lvl));

  a_r9_spurious_keeps_stack: assert property (@(posedge clk) disable iff (rst)
    (is_ivr_rd && !win_valid) |=> $stable(depth) && $stable(cur_lvl));

  a_r11_debug_read_quiet: assert property (@(posedge clk) disable iff (rst)
    (is_ivr_rd && dbg) |=> $stable(depth) && $stable(cur_lvl));

  a_r10_protected_mode: assert property (@(posedge clk) disable iff (rst)
    (prot && is_mode_wr) |=> $stable(modes[sel]));

endmodule

bind prio_irq_ctrl pic_checks #(
  .NSRC   (NSRC),
  .ADDR_W (ADDR_W),
  .SRC_W  (SRC_W),
  .LVL_W  (LVL_W),
  .DEP_W  (DEP_W)
) u_checks (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .prot       (prot_q),
  .dbg        (dbg_q),
  .sel        (sel_q),
  .modes      (src_modes),
  .src_en     (src_en),
  .win_valid  (win_valid),
  .win_idx    (win_idx),
  .cur_lvl    (cur_lvl),
  .depth      (stk_depth)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

  localparam int NSRC = 77;
  localparam logic [23:0] KEY = 24'h5EC0DE;
  localparam logic [3:0] A_SEL = 0, A_MODE = 1, A_VEC = 2, A_ENA = 3, A_DIS = 4,
                         A_CLR = 5, A_IVR = 6, A_EOI = 7, A_SPUR = 8, A_WPR = 9,
                         A_DBG = 10, A_STAT = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [3:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [NSRC-1:0]   src_in = '0;
  logic              irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .src_in(src_in), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item for each returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cfg(input int n, input logic [31:0] mode, input logic [31:0] vec);
    wr(A_SEL, n);
    wr(A_VEC, vec);
    wr(A_MODE, mode);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); src_in[n] = 1'b1;
    @(negedge clk); src_in[n] = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    // R12 reset state
    check("R12 irq after reset", irq_out, 0);
    check("R12 rvalid after reset", bus_rvalid, 0);
    rd_exp(A_STAT, 32'h00, "R12 status after reset");

    // modes: rise=1, high=0, low=2, fall=3 in [5:4]; prio in [2:0]
    cfg(3,  32'h12, 32'h103);
    cfg(5,  32'h04, 32'h105);
    cfg(10, 32'h04, 32'h10A);
    cfg(70, 32'h36, 32'h146);
    cfg(71, 32'h21, 32'h147);

    // R1 indirect access
    wr(A_SEL, 5);
    rd_exp(A_MODE, 32'h04, "R1 mode of source 5");
    rd_exp(A_VEC, 32'h105, "R1 vector of source 5");
    wr(A_SEL, 200);
    rd_exp(A_SEL, 32'd5, "R1 out of range select ignored");
    wr(A_SEL, 70);
    rd_exp(A_MODE, 32'h36, "R1 mode of source 70");

    // R3 inverted triggers only on external sources
    wr(A_SEL, 10);
    wr(A_MODE, 32'h34);
    rd_exp(A_MODE, 32'h04, "R3 falling on internal dropped");
    wr(A_MODE, 32'h27);
    rd_exp(A_MODE, 32'h04, "R3 low level on internal dropped");

    // R9 spurious
    wr(A_SPUR, 32'hDEADBEEF);
    rd_exp(A_IVR, 32'hDEADBEEF, "R9 spurious vector");
    rd_exp(A_STAT, 32'h00, "R9 stack untouched");

    // R4 rising edge, R7 acknowledge, R8 pop
    wr(A_SEL, 3);
    wr(A_ENA, 1);
    wait_n(3);
    check("R4 no edge no request", irq_out, 0);
    pulse(3);
    wait_n(4);
    check("R4 rising edge raises request", irq_out, 1);
    rd_exp(A_ENA, 32'h3, "R5 pending and enabled");
    rd_exp(A_IVR, 32'h103, "R7 winner vector");
    wait_n(2);
    check("R7 request drops after ack", irq_out, 0);
    rd_exp(A_STAT, 32'h31, "R7 level pushed");
    rd_exp(A_ENA, 32'h1, "R7 edge latch cleared by ack");
    wr(A_EOI, 0);
    rd_exp(A_STAT, 32'h00, "R8 pop to idle");
    wr(A_EOI, 0);
    rd_exp(A_STAT, 32'h00, "R8 pop on empty ignored");
    wait_n(2);
    check("R8 no request after pop", irq_out, 0);

    // R6 tie break and equal level blocking
    wr(A_SEL, 5);  wr(A_ENA, 1);
    wr(A_SEL, 10); wr(A_ENA, 1);
    @(negedge clk); src_in[5] = 1'b1; src_in[10] = 1'b1;
    wait_n(4);
    check("R6 request with two level sources", irq_out, 1);
    rd_exp(A_IVR, 32'h105, "R6 tie goes to lower number");
    wait_n(2);
    check("R6 equal priority blocked", irq_out, 0);
    rd_exp(A_STAT, 32'h51, "R6 level after tie ack");
    @(negedge clk); src_in[5] = 1'b0;
    wr(A_EOI, 0);
    wait_n(4);
    check("R6 second source after pop", irq_out, 1);
    rd_exp(A_IVR, 32'h10A, "R6 second winner vector");

    // R4 falling edge on external source, nesting
    @(negedge clk); src_in[70] = 1'b1;
    wr(A_SEL, 70); wr(A_ENA, 1);
    wait_n(3);
    check("R4 rise ignored in falling mode", irq_out, 0);
    @(negedge clk); src_in[70] = 1'b0;
    wait_n(4);
    check("R4 falling edge preempts", irq_out, 1);
    rd_exp(A_IVR, 32'h146, "R6 higher priority nests");
    rd_exp(A_STAT, 32'h72, "R8 two levels stacked");
    wr(A_EOI, 0);
    rd_exp(A_STAT, 32'h51, "R8 pop restores level");
    @(negedge clk); src_in[10] = 1'b0;
    wr(A_EOI, 0);
    rd_exp(A_STAT, 32'h00, "R8 pop to idle after nesting");
    wait_n(3);
    check("R8 quiet after nesting", irq_out, 0);

    // R5 disable, clear, enable
    wr(A_SEL, 3);
    wr(A_DIS, 1);
    pulse(3);
    wait_n(4);
    check("R5 disabled source silent", irq_out, 0);
    rd_exp(A_ENA, 32'h2, "R5 latch kept while disabled");
    wr(A_CLR, 1);
    rd_exp(A_ENA, 32'h0, "R5 clear drops latch");
    wr(A_ENA, 0);
    rd_exp(A_ENA, 32'h0, "R5 enable with bit0 low ignored");
    wr(A_ENA, 1);
    rd_exp(A_ENA, 32'h1, "R5 enable");

    // R4 low level on external source
    wr(A_SEL, 71); wr(A_ENA, 1);
    wait_n(3);
    check("R4 low level raises request", irq_out, 1);
    rd_exp(A_IVR, 32'h147, "R4 low level vector");
    @(negedge clk); src_in[71] = 1'b1;
    wr(A_EOI, 0);
    wait_n(4);
    check("R4 low level released", irq_out, 0);

    // R11 debug reads
    wr(A_DBG, 1);
    pulse(3);
    wait_n(4);
    rd_exp(A_IVR, 32'h103, "R11 debug read vector");
    rd_exp(A_STAT, 32'h00, "R11 debug read no push");
    wait_n(2);
    check("R11 request kept", irq_out, 1);
    wr(A_DBG, 0);
    rd_exp(A_IVR, 32'h103, "R11 normal read after debug");
    rd_exp(A_STAT, 32'h31, "R11 push after debug off");
    wr(A_EOI, 0);

    // R10 write protection
    wr(A_SEL, 3);
    wr(A_WPR, {KEY, 8'h01});
    rd_exp(A_WPR, 32'h1, "R10 protect set");
    wr(A_MODE, 32'h15);
    rd_exp(A_MODE, 32'h12, "R10 mode locked");
    wr(A_VEC, 32'h999);
    rd_exp(A_VEC, 32'h103, "R10 vector locked");
    wr(A_WPR, {24'h123456, 8'h00});
    rd_exp(A_WPR, 32'h1, "R10 wrong key ignored");
    wr(A_WPR, {KEY, 8'h00});
    wr(A_MODE, 32'h15);
    rd_exp(A_MODE, 32'h15, "R10 mode writable again");

    // R2 field layout
    wr(A_SEL, 5);
    wr(A_MODE, 32'hFFFF_FF0F);
    rd_exp(A_MODE, 32'h07, "R2 reserved bits read zero");

    wait_n(4);
    if (exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R12 missing read data actual=%0d expected=0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule